// File: doc/BRIEF.md
# Global-History Two-Level Branch Direction Predictor

This block predicts whether a conditional branch is taken. A short shift register records the directions of the most recent resolved branches. That history value selects one entry of a small table of 2-bit saturating counters. The prediction is taken when the selected counter is in one of its two upper states. The prediction port is combinational from the current history, so a fresh prediction is available in every cycle. The history used is also presented on an output, so the front end can keep it with the branch.

When a branch resolves, the front end sends one update. The update carries the actual direction, the history value that was captured at prediction time and the prediction that was made. The block moves the counter at the captured index one step toward the outcome. In the same clock edge it shifts the outcome into the low end of the history. An update whose outcome differs from the carried prediction raises a mispredict flag in that same cycle.

Each table entry is a four-state machine with the states S_STRONG_NT (00), S_WEAK_NT (01), S_WEAK_T (10) and S_STRONG_T (11). A taken update moves it along STRONG_NT→WEAK_NT→WEAK_T→STRONG_T and holds it in STRONG_T. A not-taken update moves it the opposite way and holds it in STRONG_NT. With no update the entry stays where it is.

Top module: `gbp_predictor`

## Requirements
- R1: After synchronous reset, the history reads 000 and every counter is in S_STRONG_NT (00), so pred_taken is 0.
- R2: pred_taken is 1 exactly when the counter selected by the current history (pred_hist) is in state 10 or 11.
- R3: A taken update moves the addressed counter up one state and saturates at 11.
- R4: A not-taken update moves the addressed counter down one state and saturates at 00.
- R5: An update writes the counter at the index given on upd_hist, whatever the current history is.
- R6: Each update makes the new history {old[1:0], upd_taken}: the outcome enters bit 0 and the oldest bit is dropped. The shift happens on the same edge as the counter write.
- R7: In a cycle with upd_valid low, neither the history nor any counter changes.
- R8: mispredict is 1 exactly when upd_valid is high and upd_taken differs from upd_pred. It is 0 in every cycle without an update.
- R9: From reset, a run of 100 taken branches followed by one not-taken branch, each updated with its own prediction and history, produces exactly 6 mispredicts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pred_taken | output | 1 | Direction predicted from the current history |
| pred_hist | output | HIST_W | Current history, used for the prediction |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_taken | input | 1 | Actual direction of the resolved branch |
| upd_hist | input | HIST_W | History captured when that branch was predicted |
| upd_pred | input | 1 | Prediction given for that branch |
| mispredict | output | 1 | Outcome differs from the carried prediction |

## Verification
A counter that steps wrongly or saturates wrongly stays hidden until the history next selects that entry. Then pred_taken differs from the model on that cycle. The bench therefore steers the history through every entry and compares on every clock. A history shift error shows on pred_hist at the first negative edge after the update. A wrong mispredict decision shows in the same cycle as the update. A counter written at the live history instead of the carried one stays hidden until that entry is selected again. The bench deliberately feeds carried histories that differ from the current one to expose this.

// File: rtl/gbp_pkg.sv
package gbp_pkg;
    typedef enum logic [1:0] {
        S_STRONG_NT = 2'b00,
        S_WEAK_NT   = 2'b01,
        S_WEAK_T    = 2'b10,
        S_STRONG_T  = 2'b11
    } ctr_e;
endpackage

// File: rtl/gbp_history.sv
module gbp_history #(
    parameter int HIST_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              shift_bit,
    output logic [HIST_W-1:0] hist
);
    logic [HIST_W-1:0] hist_q;
    logic [HIST_W-1:0] hist_d;

    always_comb begin
        hist_d = hist_q;
        if (shift_en) begin
            hist_d = {hist_q[HIST_W-2:0], shift_bit};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    assign hist = hist_q;
endmodule

// File: rtl/gbp_table.sv
module gbp_table
    import gbp_pkg::*;
#(
    parameter int HIST_W = 3,
    localparam int ENTRIES = 1 << HIST_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [HIST_W-1:0]    wr_idx,
    input  logic                 wr_taken,
    input  logic [HIST_W-1:0]    rd_idx,
    output logic                 rd_taken,
    output logic [2*ENTRIES-1:0] ctr_vec
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        ctr_e st_q;
        ctr_e st_d;
        logic hit;

        assign hit = wr_en && (wr_idx == HIST_W'(g));

        always_comb begin
            st_d = st_q;
            if (hit) begin
                unique case (st_q)
                    S_STRONG_NT: st_d = wr_taken ? S_WEAK_NT  : S_STRONG_NT;
                    S_WEAK_NT:   st_d = wr_taken ? S_WEAK_T   : S_STRONG_NT;
                    S_WEAK_T:    st_d = wr_taken ? S_STRONG_T : S_WEAK_NT;
                    S_STRONG_T:  st_d = wr_taken ? S_STRONG_T : S_WEAK_T;
                    default:     st_d = S_STRONG_NT;
                endcase
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                st_q <= S_STRONG_NT;
            end else begin
                st_q <= st_d;
            end
        end

        assign ctr_vec[2*g +: 2] = st_q;
    end

    always_comb begin
        rd_taken = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (rd_idx == HIST_W'(i)) begin
                rd_taken = ctr_vec[2*i+1];
            end
        end
    end
endmodule

// File: rtl/gbp_predictor.sv
module gbp_predictor #(
    parameter int HIST_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    output logic              pred_taken,
    output logic [HIST_W-1:0] pred_hist,
    input  logic              upd_valid,
    input  logic              upd_taken,
    input  logic [HIST_W-1:0] upd_hist,
    input  logic              upd_pred,
    output logic              mispredict
);
    localparam int ENTRIES = 1 << HIST_W;

    logic [HIST_W-1:0]    hist;
    logic [2*ENTRIES-1:0] ctr_vec;

    gbp_history #(.HIST_W(HIST_W)) hist_i (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (upd_valid),
        .shift_bit (upd_taken),
        .hist      (hist)
    );

    gbp_table #(.HIST_W(HIST_W)) table_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (upd_valid),
        .wr_idx   (upd_hist),
        .wr_taken (upd_taken),
        .rd_idx   (hist),
        .rd_taken (pred_taken),
        .ctr_vec  (ctr_vec)
    );

    assign pred_hist  = hist;
    assign mispredict = upd_valid && (upd_taken != upd_pred);
endmodule

// File: rtl/gbp_checker.sv
module gbp_checker #(
    parameter int HIST_W = 3,
    localparam int ENTRIES = 1 << HIST_W
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 pred_taken,
    input logic [HIST_W-1:0]    pred_hist,
    input logic                 upd_valid,
    input logic                 upd_taken,
    input logic [HIST_W-1:0]    upd_hist,
    input logic                 upd_pred,
    input logic                 mispredict,
    input logic [2*ENTRIES-1:0] ctr_vec
);
    function automatic logic [1:0] ctr_at(input logic [2*ENTRIES-1:0] v,
                                          input logic [HIST_W-1:0] idx);
        return v[2*idx +: 2];
    endfunction

    p_hist_shift_r6: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> pred_hist == {$past(pred_hist[HIST_W-2:0]), $past(upd_taken)});

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> ($stable(pred_hist) && $stable(ctr_vec)));

    p_idle_flag_r8: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |-> !mispredict);

    p_agree_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_taken == upd_pred) |-> !mispredict);

    p_step_up_r3: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_taken) |=>
            ctr_at(ctr_vec, $past(upd_hist)) ==
            (($past(ctr_at(ctr_vec, upd_hist)) == 2'b11) ? 2'b11
                : $past(ctr_at(ctr_vec, upd_hist)) + 2'b01));

    p_step_down_r4: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_taken) |=>
            ctr_at(ctr_vec, $past(upd_hist)) ==
            (($past(ctr_at(ctr_vec, upd_hist)) == 2'b00) ? 2'b00
                : $past(ctr_at(ctr_vec, upd_hist)) - 2'b01));

    p_read_r2: assert property (@(posedge clk) disable iff (rst)
        pred_taken == ctr_at(ctr_vec, pred_hist)[1]);
endmodule

bind gbp_predictor gbp_checker #(.HIST_W(HIST_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .pred_taken (pred_taken),
    .pred_hist  (pred_hist),
    .upd_valid  (upd_valid),
    .upd_taken  (upd_taken),
    .upd_hist   (upd_hist),
    .upd_pred   (upd_pred),
    .mispredict (mispredict),
    .ctr_vec    (ctr_vec)
);

// File: tb/gbp_predictor_tb.sv
module gbp_predictor_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pred_taken;
    logic [2:0] pred_hist;
    logic       upd_valid = 1'b0;
    logic       upd_taken = 1'b0;
    logic [2:0] upd_hist  = 3'd0;
    logic       upd_pred  = 1'b0;
    logic       mispredict;

    int checks = 0;
    int bad    = 0;
    int m_ctr [8];
    int m_hist = 0;
    int loop_miss = 0;

    always #2.5 clk = ~clk;

    gbp_predictor #(.HIST_W(3)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .pred_taken (pred_taken),
        .pred_hist  (pred_hist),
        .upd_valid  (upd_valid),
        .upd_taken  (upd_taken),
        .upd_hist   (upd_hist),
        .upd_pred   (upd_pred),
        .mispredict (mispredict)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at a negative edge: compare outputs with the model,
    // drive one cycle of update stimulus, advance the model.
    task automatic step(input bit v, input bit t, input int hx, input bit p,
                        input string tag);
        chk({tag, " R2 pred_taken"}, int'(pred_taken), (m_ctr[m_hist] >= 2) ? 1 : 0);
        chk({tag, " R6 pred_hist"}, int'(pred_hist), m_hist);
        upd_valid = v;
        upd_taken = t;
        upd_hist  = 3'(hx);
        upd_pred  = p;
        #1;
        chk({tag, " R8 mispredict"}, int'(mispredict), (v && (t != p)) ? 1 : 0);
        if (v) begin
            if (t) m_ctr[hx] = (m_ctr[hx] == 3) ? 3 : m_ctr[hx] + 1;
            else   m_ctr[hx] = (m_ctr[hx] == 0) ? 0 : m_ctr[hx] - 1;
            m_hist = ((m_hist << 1) | int'(t)) & 7;
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        int lfsr;
        for (int i = 0; i < 8; i++) m_ctr[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 reset history", int'(pred_hist), 0);
        chk("R1 reset prediction", int'(pred_taken), 0);

        // R9: 100 taken then one not-taken, each with its own prediction
        for (int i = 0; i < 101; i++) begin
            bit outcome;
            outcome = (i < 100);
            if (pred_taken != outcome) loop_miss++;
            step(1'b1, outcome, int'(pred_hist), pred_taken, "R9 loop");
        end
        chk("R9 loop mispredict count", loop_miss, 6);

        // R7: idle cycles with noisy update fields
        for (int i = 0; i < 6; i++) begin
            step(1'b0, 1'(i), i, 1'(i >> 1), "R7 idle");
        end

        // R3/R4: saturation via current index, then walk down
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, m_hist, 1'b1, "R3 sat up");
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, m_hist, 1'b0, "R4 sat down");

        // R5: update with carried history different from the current one
        for (int i = 0; i < 24; i++) begin
            step(1'b1, 1'b1, (m_hist + 3) & 7, 1'b0, "R5 stale index");
        end
        for (int i = 0; i < 8; i++) step(1'b1, 1'(i & 1), i, 1'b1, "R5 sweep");

        // Mixed pseudo-random pattern covering every entry
        lfsr = 8'h5a;
        for (int i = 0; i < 300; i++) begin
            bit fb;
            fb = lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3];
            lfsr = ((lfsr << 1) | int'(fb)) & 8'hff;
            step(lfsr[0] | lfsr[2], lfsr[1], (i % 4 == 0) ? lfsr[6:4] : m_hist,
                 lfsr[3], "R3 R4 mixed");
        end

        // R1 again: reset clears everything
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) m_ctr[i] = 0;
        m_hist = 0;
        @(negedge clk);
        chk("R1 re-reset history", int'(pred_hist), 0);
        chk("R1 re-reset prediction", int'(pred_taken), 0);
        for (int i = 0; i < 8; i++) step(1'b1, 1'b1, m_hist, 1'b0, "R1 after reset");

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule